// File: doc/BRIEF.md
# I2C Start-Condition Qualifier

This block sits on the receiving side of an I2C slave. It watches SCL and SDA after synchronizing each to the system clock. A falling SDA edge seen while SCL is high is only a candidate. The block accepts it as a start condition only after a programmable run of samples, taken on consecutive system clock cycles, all show SDA still low and SCL still high. This filters out short glitches on the bus.

An 8-bit configuration register sets the sampling. Software loads it through a single-cycle write strobe. Bit 7 selects multi-sample mode, and bits 6:0 hold the sample count. The block reports each outcome with a one-cycle pulse. A downstream address receiver uses the accept pulse to start shifting in the address byte. The reject pulse tells it that the candidate was dropped.

Top module: `i2c_start_qualifier`

## Requirements
- R1: A validation starts only when the synchronized SDA goes from 1 to 0 while the synchronized SCL is 1. SDA falling while SCL is low starts nothing. SCL rising while SDA is already low also starts nothing.
- R2: SCL and SDA each pass through a two-flop synchronizer. Suppose raw SDA is first captured low at clock edge e and sample k (k = 1, 2, ...) fails. Sample k looks at the raw values captured at edge e+k. The reject pulse is then high in the cycle after edge e+k+2. With a count of N passing samples, the accept pulse is high in the cycle after edge e+N+2.
- R3: The configuration register is 8 bits wide and resets to 00h. Bit 7 is the multi-sample flag. Bits 6:0 are the sample count. A write happens on a clock edge where cfg_we_i is 1.
- R4: When bit 7 is 0, exactly one sample is taken, one clock after the edge is detected. Bits 6:0 are then ignored.
- R5: When bit 7 is 1, the number of samples equals bits 6:0. A count of 0 is treated as 1, and the largest count is 127.
- R6: Samples fall on consecutive clock cycles. When every sample shows SDA low and SCL high, start_valid_o pulses for one cycle.
- R7: The first sample that shows SDA high or SCL low ends the validation. start_reject_o pulses for one cycle and the block returns to idle. This also applies when the failing sample is the last one. The two pulses are never high together, and neither is high for two cycles in a row.
- R8: A configuration write made while a validation is in progress is dropped. Writes made while idle apply from the next candidate on. A write in the cycle where the candidate is detected is kept, but the current candidate still uses the old setting.
- R9: SDA activity during a validation never reloads the sample counter. Only the sample checks decide the outcome. After the outcome, a new falling edge with SCL high starts a new candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL bus line |
| sda_i | input | 1 | Raw SDA bus line |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data: bit 7 is the multi-sample flag, bits 6:0 the count |
| start_valid_o | output | 1 | One-cycle pulse: start condition accepted |
| start_reject_o | output | 1 | One-cycle pulse: candidate dropped |

## Verification
The key collision is the final sample of a run being the one that fails. In that cycle, completing the count and detecting a failure both happen, and the failure must win with a reject pulse rather than an accept. The bench provokes this by holding SDA low for exactly the programmed count of synchronized cycles, so that SDA rises on the last sample. It does the same with SCL dropping on that cycle. It judges each cycle's outputs against a cycle-level model written from the requirements.

A second overlap is a configuration write that lands while a sample is being taken. The bench places such writes at random points and expects them to be dropped, which shows up in how many samples the next candidate takes.

// File: rtl/i2c_sq_pkg.sv
package i2c_sq_pkg;
  parameter int unsigned SQ_CNT_W_DEF = 7;
  parameter int unsigned SQ_SYNC_DEF  = 2;

  typedef enum logic [0:0] {
    SQ_IDLE   = 1'b0,
    SQ_SAMPLE = 1'b1
  } sq_state_e;
endpackage

// File: rtl/i2c_sq_sync.sv
module i2c_sq_sync #(
  parameter int unsigned       WIDTH   = 2,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_sq_cfg.sv
module i2c_sq_cfg #(
  parameter int unsigned CNT_W = 7,
  localparam int unsigned CFG_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             lock_i,
  output logic             multi_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CFG_W-1:0] cfg_q;

  // writes during a validation are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cfg_q <= '0;
    else if (we_i && !lock_i) cfg_q <= wdata_i;
  end

  assign multi_o = cfg_q[CFG_W-1];
  assign count_o = cfg_q[CNT_W-1:0];
endmodule

// File: rtl/i2c_sq_sampler.sv
module i2c_sq_sampler
  import i2c_sq_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic             multi_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] remaining_o,
  output logic             valid_o,
  output logic             reject_o
);
  sq_state_e        state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             sda_prev_q;
  logic             valid_d, reject_d;
  logic             cand, sample_ok;
  logic [CNT_W-1:0] load_cnt;

  assign cand      = sda_prev_q & ~sda_s_i & scl_s_i;
  assign sample_ok = ~sda_s_i & scl_s_i;
  // single sample unless multi mode with nonzero count
  assign load_cnt  = (multi_i && (count_i != '0)) ? count_i : CNT_W'(1);

  always_comb begin
    state_d  = state_q;
    rem_d    = rem_q;
    valid_d  = 1'b0;
    reject_d = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (cand) begin
          state_d = SQ_SAMPLE;
          rem_d   = load_cnt;
        end
      end
      SQ_SAMPLE: begin
        if (!sample_ok) begin
          reject_d = 1'b1;
          state_d  = SQ_IDLE;
        end else if (rem_q == CNT_W'(1)) begin
          valid_d = 1'b1;
          state_d = SQ_IDLE;
        end else begin
          rem_d = rem_q - CNT_W'(1);
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SQ_IDLE;
      rem_q      <= '0;
      sda_prev_q <= 1'b1;
      valid_o    <= 1'b0;
      reject_o   <= 1'b0;
    end else begin
      state_q    <= state_d;
      rem_q      <= rem_d;
      sda_prev_q <= sda_s_i;
      valid_o    <= valid_d;
      reject_o   <= reject_d;
    end
  end

  assign busy_o      = (state_q == SQ_SAMPLE);
  assign remaining_o = rem_q;
endmodule

// File: rtl/i2c_start_qualifier.sv
module i2c_start_qualifier
  import i2c_sq_pkg::*;
#(
  parameter int unsigned CNT_W       = SQ_CNT_W_DEF,
  parameter int unsigned SYNC_STAGES = SQ_SYNC_DEF,
  localparam int unsigned CFG_W      = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             start_valid_o,
  output logic             start_reject_o
);
  logic             scl_s, sda_s;
  logic             busy;
  logic             cfg_multi;
  logic [CNT_W-1:0] cfg_count;
  logic [CNT_W-1:0] remaining;

  i2c_sq_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_sq_cfg #(
    .CNT_W(CNT_W)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .lock_i (busy),
    .multi_o(cfg_multi),
    .count_o(cfg_count)
  );

  i2c_sq_sampler #(
    .CNT_W(CNT_W)
  ) u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .multi_i    (cfg_multi),
    .count_i    (cfg_count),
    .busy_o     (busy),
    .remaining_o(remaining),
    .valid_o    (start_valid_o),
    .reject_o   (start_reject_o)
  );
endmodule

// File: rtl/i2c_sq_checker.sv
module i2c_sq_checker #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s_i,
  input logic             sda_s_i,
  input logic             busy_i,
  input logic [CNT_W-1:0] remaining_i,
  input logic             multi_i,
  input logic [CNT_W-1:0] count_i,
  input logic             valid_i,
  input logic             reject_i
);
  // R1
  start_needs_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> ($past(scl_s_i) && !$past(sda_s_i) && $past(sda_s_i, 2)));

  // R4
  single_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_i) && !$past(multi_i)) |-> (remaining_i == CNT_W'(1)));

  // R5
  multi_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_i) && $past(multi_i) && ($past(count_i) != '0)) |-> (remaining_i == $past(count_i)));

  // R6
  pass_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !sda_s_i && scl_s_i && (remaining_i == CNT_W'(1))) |=> (valid_i && !busy_i));

  // R7
  fail_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (sda_s_i || !scl_s_i)) |=> (reject_i && !busy_i));

  // R7
  excl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && reject_i));

  // R7
  valid_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  // R7
  reject_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_i |=> !reject_i);

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(multi_i) && $stable(count_i)));

  // R9
  no_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !sda_s_i && scl_s_i && (remaining_i != CNT_W'(1)))
      |=> (busy_i && (remaining_i == $past(remaining_i) - CNT_W'(1))));
endmodule

bind i2c_start_qualifier i2c_sq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s_i    (scl_s),
  .sda_s_i    (sda_s),
  .busy_i     (busy),
  .remaining_i(remaining),
  .multi_i    (cfg_multi),
  .count_i    (cfg_count),
  .valid_i    (start_valid_o),
  .reject_i   (start_reject_o)
);

// File: tb/sim_i2c_start_qualifier.sv
module sim_i2c_start_qualifier;
  localparam int MAXL = 200;
  localparam int EXPL = MAXL + 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_i = 1'b1, sda_i = 1'b1;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic       start_valid_o, start_reject_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  bit       sda_a [MAXL];
  bit       scl_a [MAXL];
  bit       we_a  [MAXL];
  bit [7:0] wd_a  [MAXL];
  bit       exp_v [EXPL];
  bit       exp_r [EXPL];
  int       len;
  bit [7:0] cfg_m = 8'h00;

  always #2 clk = ~clk;

  i2c_start_qualifier u0 (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .scl_i         (scl_i),
    .sda_i         (sda_i),
    .cfg_we_i      (cfg_we_i),
    .cfg_wdata_i   (cfg_wdata_i),
    .start_valid_o (start_valid_o),
    .start_reject_o(start_reject_o)
  );

  function automatic bit sda_at(int r);
    if (r < 0 || r >= len) return 1'b1;
    return sda_a[r];
  endfunction
  function automatic bit scl_at(int r);
    if (r < 0 || r >= len) return 1'b1;
    return scl_a[r];
  endfunction
  function automatic bit we_at(int r);
    if (r < 0 || r >= len) return 1'b0;
    return we_a[r];
  endfunction
  function automatic bit [7:0] wd_at(int r);
    if (r < 0 || r >= len) return 8'h00;
    return wd_a[r];
  endfunction

  task automatic clear_stim(int l);
    len = l;
    for (int r = 0; r < MAXL; r++) begin
      sda_a[r] = 1'b1; scl_a[r] = 1'b1; we_a[r] = 1'b0; wd_a[r] = 8'h00;
    end
  endtask

  task automatic sda_low(int from, int n);
    for (int r = from; r < from + n && r < MAXL; r++) sda_a[r] = 1'b0;
  endtask

  task automatic scl_low(int from, int n);
    for (int r = from; r < from + n && r < MAXL; r++) scl_a[r] = 1'b0;
  endtask

  task automatic put_write(int r, bit [7:0] v);
    we_a[r] = 1'b1; wd_a[r] = v;
  endtask

  // cycle model from the requirements; interval i sees raw values captured at edge i+1
  task automatic build_expected();
    bit busy = 1'b0;
    int rem = 0;
    for (int m = 0; m < EXPL; m++) begin exp_v[m] = 1'b0; exp_r[m] = 1'b0; end
    for (int i = -2; i <= len + 6; i++) begin
      bit was_busy = busy;
      bit s_now = sda_at(i);
      bit c_now = scl_at(i);
      bit s_prev = sda_at(i - 1);
      if (i >= 0) begin
        if (!busy) begin
          if (s_prev && !s_now && c_now) begin
            busy = 1'b1;
            rem = (cfg_m[7] && cfg_m[6:0] != 0) ? int'(cfg_m[6:0]) : 1;
          end
        end else if (s_now || !c_now) begin
          exp_r[i+3] = 1'b1; busy = 1'b0;
        end else if (rem == 1) begin
          exp_v[i+3] = 1'b1; busy = 1'b0;
        end else begin
          rem--;
        end
      end
      if (!was_busy && we_at(i + 2)) cfg_m = wd_at(i + 2);
    end
  endtask

  task automatic run_case(string req);
    build_expected();
    for (int k = 0; k <= len + 9; k++) begin
      @(negedge clk);
      checks++;
      if (start_valid_o !== exp_v[k] || start_reject_o !== exp_r[k]) begin
        errors++;
        $display("FAIL %s cycle %0d valid/reject actual %b%b expected %b%b",
                 req, k, start_valid_o, start_reject_o, exp_v[k], exp_r[k]);
      end
      sda_i       = sda_at(k);
      scl_i       = scl_at(k);
      cfg_we_i    = we_at(k);
      cfg_wdata_i = wd_at(k);
    end
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R3 reset state of outputs
    checks++;
    if (start_valid_o !== 1'b0 || start_reject_o !== 1'b0) begin
      errors++;
      $display("FAIL R3 reset outputs actual %b%b expected 00", start_valid_o, start_reject_o);
    end
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R3 R4 reset config 00h: one sample
    clear_stim(12); sda_low(0, 6); run_case("R3");
    clear_stim(12); sda_low(0, 1); run_case("R2");
    // R4 flag clear ignores count field
    clear_stim(16); put_write(0, 8'h05); sda_low(4, 3); run_case("R4");
    clear_stim(16); sda_low(4, 1); run_case("R4");
    // R5 multi count 5: pass, then fail on last sample
    clear_stim(20); put_write(0, 8'h85); sda_low(4, 6); run_case("R5");
    clear_stim(20); sda_low(4, 5); run_case("R7");
    clear_stim(20); sda_low(4, 12); scl_low(9, 3); run_case("R7");
    // R5 count zero acts as one
    clear_stim(16); put_write(0, 8'h80); sda_low(4, 2); run_case("R5");
    clear_stim(16); sda_low(4, 1); run_case("R5");
    // R1 fall with SCL low, and SCL rising with SDA low
    clear_stim(24); put_write(0, 8'h83); scl_low(0, 8); sda_low(3, 12); run_case("R1");
    // R6 SCL drops mid run
    clear_stim(30); put_write(0, 8'h88); sda_low(4, 20); scl_low(8, 2); run_case("R6");
    // R8 write during validation dropped, next candidate keeps old count
    clear_stim(40); put_write(0, 8'h86); sda_low(4, 10); put_write(8, 8'h81);
    sda_low(20, 6); run_case("R8");
    clear_stim(20); sda_low(4, 6); run_case("R8");
    // R9 bounce during validation
    clear_stim(40); put_write(0, 8'h84); sda_low(4, 2); sda_low(7, 10); run_case("R9");
    // R5 largest count
    clear_stim(150); put_write(0, 8'hFF); sda_low(4, 128); run_case("R5");
    clear_stim(150); sda_low(4, 127); run_case("R5");

    // random mix
    for (int t = 0; t < 60; t++) begin
      int f, l;
      clear_stim(48);
      put_write(0, {1'($urandom % 2), 7'($urandom % 14)});
      f = 3 + int'($urandom % 4);
      l = int'($urandom % 20);
      sda_low(f, l);
      if ($urandom % 3 == 0) scl_low(f + int'($urandom % 12) - 1, 1 + int'($urandom % 3));
      if ($urandom % 3 == 0) sda_a[f + 1 + int'($urandom % 10)] = 1'b1;
      if ($urandom % 2 == 0) put_write(2 + int'($urandom % 20), 8'($urandom));
      run_case("R6");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule